// File: doc/BRIEF.md
# Pedestal-Subtracting Zero Suppressor with Alternating Block Buffers

This block sits behind a shared digitiser and cleans up its sample stream before it leaves the front end. Each incoming sample carries a channel number. The block looks up that channel's baseline in a small writable table and subtracts it. If the remainder falls short of a fixed threshold of 20 counts, the sample is discarded. Electronic noise is only a few counts, so the threshold sits well clear of it. Samples that fall under their baseline are treated as zero and discarded as well.

Surviving samples, tagged with their channel, are written into one of two buffer banks. While one bank is filling, the other is emptied through a valid/ready output stream. A block-end pulse closes the filling bank, which becomes one time block. The bank is handed to the drain side only when that side is idle. If the drain side is still busy, the request waits and the banks swap as soon as the drain finishes. Each block goes out as a header word, which carries a running block number and the word count, followed by the stored words in arrival order.

Capture never waits on the reader. A bank that is already full drops further hits and raises a sticky overflow flag.

Top module: `pedsub_pingpong`

## Requirements
- R1: After reset, `out_valid` and `overflow` are low, every baseline in the table is zero, and the first block is numbered 0.
- R2: A kept sample leaves as one data beat. Bits [15:12] of the beat hold the channel, and bits [11:0] hold the sample minus that channel's baseline.
- R3: A kept sample must have a remainder of at least 20. A remainder of 19 or less is dropped, and exactly 20 is kept.
- R4: A sample smaller than its channel's baseline saturates to zero and is dropped.
- R5: A baseline write applies to samples in later cycles. A sample arriving in the same cycle as the write uses the previous baseline.
- R6: A block-end pulse while `out_valid` is low starts output in the next cycle. The first beat is a header with `out_hdr` high, bits [15:5] holding the block number and bits [4:0] holding the word count.
- R7: The data beats follow the header in arrival order, and `out_last` marks the final beat. An empty block is a single header beat with `out_last` high.
- R8: The block number rises by one per block, modulo 2^11.
- R9: Samples keep being captured while a block is being output, and they land in the next block.
- R10: A block-end pulse that arrives while a block is still being output is not lost. That block is output right after the current one.
- R11: A bank holds at most 16 words. A kept sample that arrives when the bank is full is dropped, and `overflow` goes high and stays high until reset.
- R12: While `out_valid` is high and `out_ready` is low, `out_data`, `out_hdr` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 4 | Channel of the sample |
| in_sample | input | 12 | Raw digitised value |
| ped_we | input | 1 | Baseline table write strobe |
| ped_addr | input | 4 | Channel whose baseline is written |
| ped_val | input | 12 | New baseline value |
| blk_end | input | 1 | Close the filling bank as a block |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Reader accepts the beat |
| out_data | output | 16 | Header or data word |
| out_hdr | output | 1 | Beat is a header |
| out_last | output | 1 | Final beat of a block |
| overflow | output | 1 | Sticky bank-full drop flag |

## Verification
The bench aims at the threshold edge, with remainders of 19 and 20, and at samples below their baseline. A wrong comparison or a wraparound subtraction would leak noise words or drop real hits. It writes a baseline in the same cycle as a sample on that channel, which exposes a table that forwards the new value too early. It stalls the reader while new samples and a second block-end arrive. A design that stalled capture, dropped the deferred block or misplaced those samples would show wrong counts or a missing header. It also overfills one bank and closes an empty one, which catches an off-by-one bank limit, a non-sticky flag and an empty block without `out_last`.

// File: rtl/zsp_pkg.sv
package zsp_pkg;
    localparam int DATA_W = 12;
    localparam int CH_W   = 4;
    localparam int DEPTH  = 16;
    localparam int THRESH = 20;

    localparam int NCH    = 1 << CH_W;
    localparam int OUT_W  = CH_W + DATA_W;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int SEQ_W  = OUT_W - CNT_W;

    typedef struct packed {
        logic [CH_W-1:0]   chan;
        logic [DATA_W-1:0] val;
    } hit_t;

    function automatic logic [OUT_W-1:0] mk_header(input logic [SEQ_W-1:0] s,
                                                   input logic [CNT_W-1:0] n);
        return {s, n};
    endfunction
endpackage

// File: rtl/zsp_pedtab.sv
module zsp_pedtab
    import zsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CH_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CH_W-1:0]   chan,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] diff,
    output logic              pass
);
    logic [DATA_W-1:0] tab [NCH];
    logic [DATA_W-1:0] base;
    logic              under;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) tab[i] <= '0;
        end else if (we) begin
            tab[waddr] <= wdata;
        end
    end

    always_comb begin
        base  = tab[chan];
        under = sample < base;
        diff  = under ? '0 : sample - base;
        pass  = !under && (diff >= DATA_W'(THRESH));
    end
endmodule

// File: rtl/zsp_bank.sv
module zsp_bank
    import zsp_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic             wsel,
    input  logic [IDX_W-1:0] widx,
    input  hit_t             wdata,
    input  logic             rsel,
    input  logic [IDX_W-1:0] ridx,
    output hit_t             rdata
);
    hit_t bank_q [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        hit_t mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (wsel == 1'(b))) mem[widx] <= wdata;
        end
        assign bank_q[b] = mem[ridx];
    end

    assign rdata = bank_q[rsel];
endmodule

// File: rtl/zsp_drain.sv
module zsp_drain
    import zsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic [SEQ_W-1:0] start_seq,
    input  hit_t             rdata,
    input  logic             out_ready,
    output logic             busy,
    output logic [IDX_W-1:0] rd_idx,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_hdr,
    output logic             out_last
);
    logic             in_hdr;
    logic [CNT_W-1:0] cnt;
    logic [SEQ_W-1:0] seq;
    logic             at_end;

    assign at_end = in_hdr ? (cnt == '0) : ((CNT_W'(rd_idx) + CNT_W'(1)) == cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            in_hdr <= 1'b0;
            rd_idx <= '0;
            cnt    <= '0;
            seq    <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            in_hdr <= 1'b1;
            rd_idx <= '0;
            cnt    <= start_cnt;
            seq    <= start_seq;
        end else if (busy && out_ready) begin
            if (at_end) busy <= 1'b0;
            if (in_hdr) in_hdr <= 1'b0;
            else        rd_idx <= rd_idx + IDX_W'(1);
        end
    end

    assign out_valid = busy;
    assign out_hdr   = busy && in_hdr;
    assign out_last  = busy && at_end;
    assign out_data  = in_hdr ? mk_header(seq, cnt) : OUT_W'(rdata);
endmodule

// File: rtl/pedsub_pingpong.sv
module pedsub_pingpong
    import zsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              ped_we,
    input  logic [CH_W-1:0]   ped_addr,
    input  logic [DATA_W-1:0] ped_val,
    input  logic              blk_end,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_hdr,
    output logic              out_last,
    output logic              overflow
);
    logic [DATA_W-1:0] diff;
    logic              pass;
    logic              fill_sel;
    logic [CNT_W-1:0]  fill_cnt;
    logic [SEQ_W-1:0]  seq;
    logic              pend;
    logic              busy;
    logic [IDX_W-1:0]  rd_idx;
    hit_t              rd_word;
    logic              room, wr, swap;

    zsp_pedtab u_tab (
        .clk(clk), .rst(rst), .we(ped_we), .waddr(ped_addr), .wdata(ped_val),
        .chan(in_chan), .sample(in_sample), .diff(diff), .pass(pass)
    );

    assign room = fill_cnt < CNT_W'(DEPTH);
    assign wr   = in_valid && pass && room;
    assign swap = (blk_end || pend) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_sel <= 1'b0;
            fill_cnt <= '0;
            seq      <= '0;
            pend     <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (in_valid && pass && !room) overflow <= 1'b1;
            if (swap) begin
                fill_sel <= ~fill_sel;
                fill_cnt <= '0;
                seq      <= seq + SEQ_W'(1);
                pend     <= 1'b0;
            end else begin
                if (wr)      fill_cnt <= fill_cnt + CNT_W'(1);
                if (blk_end) pend     <= 1'b1;
            end
        end
    end

    zsp_bank u_bank (
        .clk(clk), .we(wr), .wsel(fill_sel), .widx(fill_cnt[IDX_W-1:0]),
        .wdata('{chan: in_chan, val: diff}),
        .rsel(~fill_sel), .ridx(rd_idx), .rdata(rd_word)
    );

    zsp_drain u_drain (
        .clk(clk), .rst(rst), .start(swap),
        .start_cnt(fill_cnt + CNT_W'(wr)), .start_seq(seq),
        .rdata(rd_word), .out_ready(out_ready), .busy(busy), .rd_idx(rd_idx),
        .out_valid(out_valid), .out_data(out_data), .out_hdr(out_hdr),
        .out_last(out_last)
    );
endmodule

// File: rtl/zsp_checker.sv
module zsp_checker
    import zsp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             blk_end,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             out_hdr,
    input logic             out_last,
    input logic             overflow
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !out_valid && !overflow);

    p_start_hdr_r6: assert property (@(posedge clk) disable iff (rst)
        blk_end && !out_valid |=> out_valid && out_hdr);

    p_next_is_hdr_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> !out_valid || out_hdr);

    p_empty_last_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_hdr && (out_data[CNT_W-1:0] == '0) |-> out_last);

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_hdr |-> out_data[CNT_W-1:0] <= CNT_W'(DEPTH));

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_hdr) && $stable(out_last));
endmodule

bind pedsub_pingpong zsp_checker u_chk (
    .clk(clk), .rst(rst), .blk_end(blk_end), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_hdr(out_hdr),
    .out_last(out_last), .overflow(overflow)
);

// File: tb/sim_pedsub_pingpong.sv
module sim_pedsub_pingpong;
    import zsp_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, ped_we = 1'b0, blk_end = 1'b0, out_ready = 1'b0;
    logic [CH_W-1:0]   in_chan = '0, ped_addr = '0;
    logic [DATA_W-1:0] in_sample = '0, ped_val = '0;
    logic              out_valid, out_hdr, out_last, overflow;
    logic [OUT_W-1:0]  out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    pedsub_pingpong u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .ped_we(ped_we), .ped_addr(ped_addr),
        .ped_val(ped_val), .blk_end(blk_end), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_hdr(out_hdr),
        .out_last(out_last), .overflow(overflow)
    );

    typedef struct {
        logic             hdr;
        logic             last;
        logic [OUT_W-1:0] data;
        string            tag;
    } beat_t;

    beat_t             expq [$];
    beat_t             fillq [$];
    logic [DATA_W-1:0] m_ped [NCH];
    logic [SEQ_W-1:0]  m_seq = '0;
    bit                m_ovf = 0;
    bit                hold = 0;
    bit                done = 0;
    int                n_chk = 0, n_bad = 0;

    function automatic bit m_keep(logic [DATA_W-1:0] s, logic [DATA_W-1:0] p);
        return (s >= p) && ((s - p) >= DATA_W'(THRESH));
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic collect();
        beat_t e;
        out_ready = hold ? 1'b0 : ($urandom % 4 != 0);
        if (out_valid && out_ready) begin
            n_chk++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected beat: got data=%h hdr=%0b, expected none",
                         out_data, out_hdr);
            end else begin
                e = expq.pop_front();
                if (out_data !== e.data || out_hdr !== e.hdr || out_last !== e.last) begin
                    n_bad++;
                    $display("FAIL %s: got data=%h hdr=%0b last=%0b expected data=%h hdr=%0b last=%0b",
                             e.tag, out_data, out_hdr, out_last, e.data, e.hdr, e.last);
                end
            end
        end
    endtask

    task automatic tick();
        @(negedge clk);
        collect();
        in_valid = 1'b0;
        blk_end  = 1'b0;
        ped_we   = 1'b0;
    endtask

    task automatic put(int ch, int val, string tag);
        beat_t b;
        in_valid  = 1'b1;
        in_chan   = CH_W'(ch);
        in_sample = DATA_W'(val);
        if (m_keep(DATA_W'(val), m_ped[ch])) begin
            if (fillq.size() < DEPTH) begin
                b.hdr = 0; b.last = 0; b.tag = tag;
                b.data = {CH_W'(ch), DATA_W'(val) - m_ped[ch]};
                fillq.push_back(b);
            end else m_ovf = 1;
        end
    endtask

    task automatic pedw(int ch, int val);
        ped_we   = 1'b1;
        ped_addr = CH_W'(ch);
        ped_val  = DATA_W'(val);
        m_ped[ch] = DATA_W'(val);
    endtask

    task automatic close(string tag);
        beat_t h;
        blk_end = 1'b1;
        h.hdr = 1; h.tag = tag;
        h.data = mk_header(m_seq, CNT_W'(fillq.size()));
        h.last = (fillq.size() == 0);
        expq.push_back(h);
        foreach (fillq[i]) begin
            fillq[i].last = (i == fillq.size() - 1);
            expq.push_back(fillq[i]);
        end
        fillq.delete();
        m_seq = m_seq + SEQ_W'(1);
    endtask

    task automatic drain_all();
        for (int k = 0; k < 2000 && (expq.size() != 0 || out_valid); k++) tick();
        check(expq.size() == 0, "R7 all expected beats seen", expq.size(), 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [OUT_W-1:0] held;
        void'($urandom(32'd4242));
        for (int i = 0; i < NCH; i++) m_ped[i] = '0;
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: idle after reset
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(overflow == 1'b0, "R1 overflow after reset", overflow, 0);

        // R2 R3 R4 R5 directed
        pedw(3, 100); tick();
        put(3, 120, "R3 remainder 20 kept"); tick();
        put(3, 119, "R3 remainder 19 dropped"); tick();
        put(3, 90, "R4 under baseline dropped"); tick();
        put(5, 20, "R2 zero baseline"); tick();
        put(3, 130, "R5 same-cycle uses old baseline"); pedw(3, 50); tick();
        put(3, 130, "R5 new baseline applies"); tick();
        put(7, 4095, "R2 full scale"); tick();
        close("R6 first header seq 0"); tick();
        drain_all();

        // R7 R8: empty block
        close("R7 empty block header only"); tick();
        drain_all();

        // R11: overflow
        check(overflow == 1'b0, "R11 no overflow yet", overflow, 0);
        for (int i = 0; i < DEPTH + 3; i++) begin
            put(i % NCH, 200 + i, "R11 bank fill");
            tick();
        end
        check(overflow == 1'b1, "R11 overflow raised", overflow, 1);
        close("R11 header count capped"); tick();
        drain_all();
        check(overflow == 1'b1, "R11 overflow sticky", overflow, 1);

        // R9 R10 R12: stall, capture during drain, deferred close
        hold = 1;
        for (int i = 0; i < 5; i++) begin put(i, 300 + i, "R9 block A"); tick(); end
        close("R10 block A header"); tick();
        tick();
        held = out_data;
        for (int i = 0; i < 3; i++) begin put(8 + i, 400 + i, "R9 captured during drain"); tick(); end
        close("R10 deferred block B header"); tick();
        tick(); tick();
        check(out_valid == 1'b1 && out_data == held, "R12 held under stall", out_data, held);
        hold = 0;
        drain_all();

        // Random mix
        for (int i = 0; i < NCH; i++) begin pedw(i, $urandom % 60); tick(); end
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 2 == 0) put($urandom % NCH, $urandom % 140, "R2 random sample");
            if (($urandom % 10 == 0) && !out_valid) close("R8 random block");
            if ($urandom % 50 == 0) pedw($urandom % NCH, $urandom % 60);
            tick();
        end
        close("R8 final block"); tick();
        drain_all();
        check(overflow == 1'(m_ovf), "R11 overflow matches model", overflow, m_ovf);

        summary();
        $finish;
    end
endmodule